// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the line, frame, data-enable and pixel-clock signals for a parallel RGB panel. It runs on the system clock and advances one pixel each time the pixel-clock enable input is high. Pixel data, palette lookup and clock division are handled elsewhere. A small register port sets the active area, the porches, the sync pulse widths and the output polarities. Each line and each frame runs in a fixed order: sync pulse, back porch, active region, front porch.

The active width is written as a count of 16-pixel groups minus one. The active height is written as a line count minus one. In the wide build, the top bit of each of these fields sits apart from its lower bits, and the block puts the field back together before using it. Software writes all timing and polarity fields first and sets the run bit last. While the raster runs, and while it is finishing its last frame, timing writes are refused. Clearing the run bit lets the current frame finish. When that frame ends, a done flag is set. A separate sticky flag records each end of frame. Both flags are cleared by writing 1 to them.

Top module: `lcdt_raster_top`

## Requirements
- R1: The active pixels per line are (P+1)×16. The 7-bit P (wide build) is assembled from timing word 1: bits [9:4] give P[5:0] and bit 3 gives P[6].
- R2: The active lines per frame are L+1. The 11-bit L is assembled from timing word 2, where bits [9:0] give L[9:0], and from bit 0 of the auxiliary word, which gives L[10].
- R3: Each line lasts (hsw+1) + (hbp+1) + active + (hfp+1) pixel strobes, in the order sync, back porch, active, front porch. The fields sit in timing word 1: hsw in bits [15:10], hbp in bits [23:16] and hfp in bits [31:24]. The line sync output is high during the sync interval, before polarity is applied.
- R4: Each frame lasts (vsw+1) + (vbp+1) + active + (vfp+1) lines, in the same order. The fields sit in timing word 2: vsw in bits [15:10], vbp in bits [23:16] and vfp in bits [31:24]. The line counter advances on the last pixel strobe of each line, and the frame sync output is high during the vertical sync interval.
- R5: Data-enable is high only when both the pixel position and the line position are inside their active regions.
- R6: Bits 1, 2 and 3 of the auxiliary word invert the pixel clock, line sync and frame sync outputs. While the raster is idle, each of these outputs rests at its inactive level: 0 XOR its invert bit.
- R7: Counters advance only on cycles where the pixel-clock enable is high. While the raster runs, the pixel clock output is high in those cycles, before polarity is applied.
- R8: End of frame is a one-cycle pulse on the last pixel strobe of the last active line. It sets status bit 1, which stays set until 1 is written to it.
- R9: Clearing bit 0 of the control word lets the current frame run to its last pixel. The raster then stops and sets status bit 0, which is cleared by writing 1 to it. Register addresses: 0 control, 1 timing word 1, 2 timing word 2, 3 auxiliary, 4 status.
- R10: Writes to timing words 1 and 2 and to the auxiliary word have no effect while the run bit is set or the last frame is still finishing.
- R11: After a synchronous active-low reset, the raster is idle, all fields and status bits are zero, and data-enable and end of frame are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable, one strobe per pixel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| pclk_o | output | 1 | Pixel clock output |
| lsync_o | output | 1 | Line sync output |
| fsync_o | output | 1 | Frame sync output |
| de_o | output | 1 | Data-enable output |
| eof_o | output | 1 | End-of-frame pulse |

## Verification
The hardest case to reach from the ports is a shutdown that is still finishing. The run bit is already clear, yet the raster must keep producing a correct frame while it refuses new timing writes. The stimulus clears the run bit partway through a frame and then writes a different timing word at once. It reads that word back before the done flag appears, and the reference model checks the remaining lines cycle by cycle until the stop. The split high bits of width and height are reached with two tailored configurations. One uses a single 1040-pixel-wide line pair; the other uses a 16-pixel-wide frame of 1025 lines. In each case, the data-enable cycles in one frame are counted.

// File: rtl/lcdt_pkg.sv
// Shared constants and the timing configuration record for the raster generator.
package lcdt_pkg;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_HTIM = 3'd1;
    localparam logic [2:0] A_VTIM = 3'd2;
    localparam logic [2:0] A_AUX  = 3'd3;
    localparam logic [2:0] A_STAT = 3'd4;

    // Field widths sized for the wide build; the narrow build forces top bits to 0.
    typedef struct packed {
        logic [6:0]  ppl;
        logic [5:0]  hsw;
        logic [7:0]  hbp;
        logic [7:0]  hfp;
        logic [10:0] lpp;
        logic [5:0]  vsw;
        logic [7:0]  vbp;
        logic [7:0]  vfp;
        logic        inv_p;
        logic        inv_l;
        logic        inv_f;
    } timing_cfg_t;

endpackage

// File: rtl/lcdt_axis_counter.sv
// One timing axis: counts positions through sync, back porch, active, front porch.
// Assumes the interval lengths stay constant while counting (the register block
// freezes them while the raster runs). Used for both pixels and lines.
module lcdt_axis_counter #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [5:0]    sync_len,
    input  logic [7:0]    bp_len,
    input  logic [7:0]    fp_len,
    input  logic [CW-1:0] act_len,
    output logic [CW-1:0] cnt,
    output logic          in_sync,
    output logic          in_act,
    output logic          at_last,
    output logic          at_last_act
);

    logic [CW-1:0] sync_end;
    logic [CW-1:0] act_beg;
    logic [CW-1:0] act_end;
    logic [CW-1:0] total;

    // Region boundaries: each porch and sync field counts as value + 1 periods.
    always_comb begin
        sync_end = CW'(sync_len) + CW'(1);
        act_beg  = sync_end + CW'(bp_len) + CW'(1);
        act_end  = act_beg + act_len;
        total    = act_end + CW'(fp_len) + CW'(1);
    end

    assign in_sync     = (cnt < sync_end);
    assign in_act      = (cnt >= act_beg) && (cnt < act_end);
    assign at_last     = (cnt == total - CW'(1));
    assign at_last_act = (cnt == act_end - CW'(1));

    // Position counter: held at zero when cleared, wraps after the last position.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= at_last ? '0 : cnt + CW'(1);
        end
    end

    // R3 / R4: the position never leaves the programmed period.
    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < total);

endmodule

// File: rtl/lcdt_regs.sv
// Register file: run bit, timing words, polarity/aux word and W1C status.
// Timing fields are accepted only while the raster is fully idle and the run
// bit is clear. In the wide build, split high bits are reassembled on write.
module lcdt_regs
    import lcdt_pkg::*;
#(
    parameter bit WIDE = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [2:0]  addr,
    input  logic [31:0] wdata,
    input  logic        active,
    input  logic        done_set,
    input  logic        eof_set,
    output logic        run_en,
    output timing_cfg_t cfg,
    output logic [31:0] rdata
);

    logic ppl_hi;
    logic lpp_hi;
    logic cfg_open;
    logic st_done;
    logic st_eof;
    logic stat_wr;

    // Pick where the top width/height bits come from for this build.
    generate
        if (WIDE) begin : g_wide
            assign ppl_hi = wdata[3];
            assign lpp_hi = wdata[0];
        end else begin : g_narrow
            assign ppl_hi = 1'b0;
            assign lpp_hi = 1'b0;
        end
    endgenerate

    assign cfg_open = !active && !run_en;
    assign stat_wr  = wr && (addr == A_STAT);

    // Control and timing field storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en <= 1'b0;
            cfg    <= '0;
        end else if (wr) begin
            if (addr == A_CTRL) begin
                run_en <= wdata[0];
            end else if (addr == A_HTIM && cfg_open) begin
                cfg.ppl <= {ppl_hi, wdata[9:4]};
                cfg.hsw <= wdata[15:10];
                cfg.hbp <= wdata[23:16];
                cfg.hfp <= wdata[31:24];
            end else if (addr == A_VTIM && cfg_open) begin
                cfg.lpp[9:0] <= wdata[9:0];
                cfg.vsw      <= wdata[15:10];
                cfg.vbp      <= wdata[23:16];
                cfg.vfp      <= wdata[31:24];
            end else if (addr == A_AUX && cfg_open) begin
                cfg.lpp[10] <= lpp_hi;
                cfg.inv_p   <= wdata[1];
                cfg.inv_l   <= wdata[2];
                cfg.inv_f   <= wdata[3];
            end
        end
    end

    // Sticky status: a new event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_done <= 1'b0;
            st_eof  <= 1'b0;
        end else begin
            st_done <= (st_done && !(stat_wr && wdata[0])) || done_set;
            st_eof  <= (st_eof  && !(stat_wr && wdata[1])) || eof_set;
        end
    end

    // Read mux for the addressed register.
    always_comb begin
        case (addr)
            A_CTRL:  rdata = {31'd0, run_en};
            A_HTIM:  rdata = {cfg.hfp, cfg.hbp, cfg.hsw, cfg.ppl[5:0], cfg.ppl[6], 3'd0};
            A_VTIM:  rdata = {cfg.vfp, cfg.vbp, cfg.vsw, cfg.lpp[9:0]};
            A_AUX:   rdata = {28'd0, cfg.inv_f, cfg.inv_l, cfg.inv_p, cfg.lpp[10]};
            A_STAT:  rdata = {30'd0, st_eof, st_done};
            default: rdata = 32'd0;
        endcase
    end

    // R10: timing fields do not move while the raster is running.
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> $stable(cfg));

    // R9: the done flag only appears as the raster leaves the running state.
    a_r9_done_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_done) |-> ($past(active) && !active));

endmodule

// File: rtl/lcdt_raster_top.sv
// Raster timing generator top: run/stop sequencing, two axis counters, and
// output shaping with polarity. Assumes pix_en is a one-cycle pixel strobe
// from an external divider; clearing the run bit finishes the current frame.
module lcdt_raster_top
    import lcdt_pkg::*;
#(
    parameter bit WIDE = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pix_en,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        pclk_o,
    output logic        lsync_o,
    output logic        fsync_o,
    output logic        de_o,
    output logic        eof_o
);

    localparam int PPL_W = WIDE ? 7 : 6;
    localparam int LPP_W = WIDE ? 11 : 10;
    localparam int HCW   = PPL_W + 6;
    localparam int VCW   = LPP_W + 2;

    timing_cfg_t cfg;
    logic        run_en;
    logic        active;
    logic        h_step, v_step;
    logic        frame_last;
    logic        done_set;
    logic [HCW-1:0] h_act_len, h_cnt;
    logic [VCW-1:0] v_act_len, v_cnt;
    logic h_sync, h_act, h_last, h_last_act;
    logic v_sync, v_act, v_last, v_last_act;

    assign h_act_len  = (HCW'(cfg.ppl) + HCW'(1)) << 4;
    assign v_act_len  = VCW'(cfg.lpp) + VCW'(1);
    assign h_step     = active && pix_en;
    assign v_step     = h_step && h_last;
    assign frame_last = v_step && v_last;
    assign done_set   = frame_last && !run_en;

    lcdt_regs #(.WIDE(WIDE)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .active   (active),
        .done_set (done_set),
        .eof_set  (eof_o),
        .run_en   (run_en),
        .cfg      (cfg),
        .rdata    (reg_rdata)
    );

    lcdt_axis_counter #(.CW(HCW)) u_hcnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (!active),
        .step        (h_step),
        .sync_len    (cfg.hsw),
        .bp_len      (cfg.hbp),
        .fp_len      (cfg.hfp),
        .act_len     (h_act_len),
        .cnt         (h_cnt),
        .in_sync     (h_sync),
        .in_act      (h_act),
        .at_last     (h_last),
        .at_last_act (h_last_act)
    );

    lcdt_axis_counter #(.CW(VCW)) u_vcnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (!active),
        .step        (v_step),
        .sync_len    (cfg.vsw),
        .bp_len      (cfg.vbp),
        .fp_len      (cfg.vfp),
        .act_len     (v_act_len),
        .cnt         (v_cnt),
        .in_sync     (v_sync),
        .in_act      (v_act),
        .at_last     (v_last),
        .at_last_act (v_last_act)
    );

    // Run state: start from idle when enabled, stop at a frame end once disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
        end else if (!active) begin
            active <= run_en;
        end else if (frame_last && !run_en) begin
            active <= 1'b0;
        end
    end

    // Output shaping with per-signal polarity.
    assign pclk_o  = (active && pix_en) ^ cfg.inv_p;
    assign lsync_o = (active && h_sync) ^ cfg.inv_l;
    assign fsync_o = (active && v_sync) ^ cfg.inv_f;
    assign de_o    = active && h_act && v_act;
    assign eof_o   = h_step && h_last && v_last_act;

    // R8: the end-of-frame pulse never lasts two cycles.
    a_r8_eof_single: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o |=> !eof_o);

    // R5: data-enable never overlaps a sync interval on either axis.
    a_r5_de_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> (!h_sync && !v_sync && active));

    // R7: counters hold still on cycles without a pixel strobe.
    a_r7_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !pix_en && $past(active)) |=> $stable(h_cnt) || !active);

endmodule

// File: tb/tb_lcdt_raster_top.sv
module tb_lcdt_raster_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_en = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd4;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pclk_o, lsync_o, fsync_o, de_o, eof_o;

    int checks = 0;
    int fails = 0;
    int pe_mode = 0;
    int cyc = 0;
    bit model_cmp = 1'b1;

    always #5 clk = ~clk;

    lcdt_raster_top dut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pclk_o(pclk_o), .lsync_o(lsync_o), .fsync_o(fsync_o),
        .de_o(de_o), .eof_o(eof_o)
    );

    // Reference model state (behavioural, integer based).
    int m_ppl, m_hsw, m_hbp, m_hfp, m_lpp, m_vsw, m_vbp, m_vfp;
    bit m_ip, m_il, m_if, m_en, m_act, m_done, m_eofs;
    int m_h, m_v;

    function automatic int h_total();
        return m_hsw + m_hbp + m_hfp + 3 + (m_ppl + 1) * 16;
    endfunction
    function automatic int v_total();
        return m_vsw + m_vbp + m_vfp + 3 + m_lpp + 1;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Pixel strobe pattern source.
    always @(negedge clk) begin
        cyc++;
        pix_en <= (pe_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    end

    // Model update on each rising edge from the bench-driven inputs.
    always @(posedge clk) begin
        bit o_act, o_en, step, hl, vl, vla, dset, eset;
        if (!rst_n) begin
            m_ppl = 0; m_hsw = 0; m_hbp = 0; m_hfp = 0;
            m_lpp = 0; m_vsw = 0; m_vbp = 0; m_vfp = 0;
            m_ip = 0; m_il = 0; m_if = 0; m_en = 0; m_act = 0;
            m_done = 0; m_eofs = 0; m_h = 0; m_v = 0;
        end else begin
            o_act = m_act; o_en = m_en;
            step = o_act && pix_en;
            hl  = (m_h == h_total() - 1);
            vl  = (m_v == v_total() - 1);
            vla = (m_v == m_vsw + m_vbp + 2 + m_lpp);
            eset = step && hl && vla;
            dset = 0;
            if (!o_act) begin
                m_act = o_en;
            end else if (step) begin
                if (hl) begin
                    m_h = 0;
                    if (vl) begin
                        m_v = 0;
                        if (!o_en) begin m_act = 0; dset = 1; end
                    end else m_v = m_v + 1;
                end else m_h = m_h + 1;
            end
            if (reg_wr) begin
                if (reg_addr == 3'd0) m_en = reg_wdata[0];
                else if (reg_addr == 3'd1 && !o_act && !o_en) begin
                    m_ppl = {reg_wdata[3], reg_wdata[9:4]};
                    m_hsw = reg_wdata[15:10]; m_hbp = reg_wdata[23:16]; m_hfp = reg_wdata[31:24];
                end else if (reg_addr == 3'd2 && !o_act && !o_en) begin
                    m_lpp = (m_lpp & 1024) | reg_wdata[9:0];
                    m_vsw = reg_wdata[15:10]; m_vbp = reg_wdata[23:16]; m_vfp = reg_wdata[31:24];
                end else if (reg_addr == 3'd3 && !o_act && !o_en) begin
                    m_lpp = (m_lpp & 1023) | (reg_wdata[0] ? 1024 : 0);
                    m_ip = reg_wdata[1]; m_il = reg_wdata[2]; m_if = reg_wdata[3];
                end
            end
            if (reg_wr && reg_addr == 3'd4) begin
                if (reg_wdata[0]) m_done = 0;
                if (reg_wdata[1]) m_eofs = 0;
            end
            if (dset) m_done = 1;
            if (eset) m_eofs = 1;
        end
    end

    // Compare every cycle, away from the clock edge.
    always @(posedge clk) begin
        int hb, he, vb, ve;
        bit hs, vs, ha, va, el;
        #3;
        if (rst_n && model_cmp) begin
            hb = m_hsw + m_hbp + 2; he = hb + (m_ppl + 1) * 16;
            vb = m_vsw + m_vbp + 2; ve = vb + m_lpp + 1;
            hs = m_h < m_hsw + 1; vs = m_v < m_vsw + 1;
            ha = (m_h >= hb) && (m_h < he); va = (m_v >= vb) && (m_v < ve);
            el = m_act && pix_en && (m_h == h_total() - 1) && (m_v == ve - 1);
            chk("R3", lsync_o, (m_act && hs) ^ m_il, "line sync");
            chk("R4", fsync_o, (m_act && vs) ^ m_if, "frame sync");
            chk("R5", de_o, m_act && ha && va, "data enable");
            chk("R7", pclk_o, (m_act && pix_en) ^ m_ip, "pixel clock");
            chk("R8", eof_o, el, "end of frame");
            if (reg_addr == 3'd4)
                chk("R9", reg_rdata, {30'd0, m_eofs, m_done}, "status");
        end
    end

    task automatic wr_reg(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'd4; reg_wdata = '0;
    endtask

    task automatic rd_chk(logic [2:0] a, logic [31:0] exp, string tag, string what);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp, what);
        reg_addr = 3'd4;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 60000; i++) begin
            @(posedge clk); #3;
            if (reg_rdata[0]) return;
        end
        chk("R9", 0, 1, "done flag never set");
    endtask

    task automatic count_de_to_eof(output int n);
        n = 0;
        for (int i = 0; i < 60000; i++) begin
            @(posedge clk); #3;
            if (de_o) n++;
            if (eof_o) return;
        end
        n = -1;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R11: reset state
        chk("R11", {pclk_o, lsync_o, fsync_o, de_o, eof_o}, 5'b0, "idle outputs");
        chk("R11", reg_rdata, 32'd0, "status after reset");
        rd_chk(3'd1, 32'd0, "R11", "timing word 1 after reset");

        // Config A: 16 px, hsw1 hbp2 hfp1; 3 lines, vsw0 vbp1 vfp0.
        wr_reg(3'd1, 32'h0102_0400);
        wr_reg(3'd2, 32'h0001_0002);
        wr_reg(3'd0, 32'd1);
        count_de_to_eof(n);
        chk("R5", n, 48, "de cycles in frame A");
        repeat (300) @(posedge clk);
        // R10: write while running is refused
        wr_reg(3'd1, 32'h1111_1110);
        rd_chk(3'd1, 32'h0102_0400, "R10", "timing word 1 locked while running");

        // R7: gated pixel strobe
        pe_mode = 1;
        repeat (600) @(posedge clk);

        // R9/R10: disable mid-frame, try a write while finishing
        wr_reg(3'd0, 32'd0);
        wr_reg(3'd2, 32'h0505_0505);
        rd_chk(3'd2, 32'h0001_0002, "R10", "timing word 2 locked while finishing");
        wait_done();
        pe_mode = 0;
        repeat (3) @(negedge clk);
        #1;
        chk("R9", de_o, 0, "de low after stop");
        chk("R9", reg_rdata, 32'd3, "done and eof flags after stop");
        wr_reg(3'd4, 32'd1);
        rd_chk(3'd4, 32'd2, "R9", "done cleared by write 1");
        wr_reg(3'd4, 32'd2);
        rd_chk(3'd4, 32'd0, "R8", "eof flag cleared by write 1");

        // R6: polarity, idle levels
        wr_reg(3'd3, 32'h0000_000E);
        @(negedge clk); #1;
        chk("R6", {pclk_o, lsync_o, fsync_o, de_o}, 4'b1110, "inverted idle levels");
        wr_reg(3'd0, 32'd1);
        repeat (400) @(posedge clk);
        wr_reg(3'd0, 32'd0);
        wait_done();
        wr_reg(3'd4, 32'd3);

        // R1: wide width, P = 64 via bit 3 only; 2 lines.
        wr_reg(3'd3, 32'd0);
        wr_reg(3'd1, 32'h0000_0008);
        wr_reg(3'd2, 32'h0000_0001);
        rd_chk(3'd1, 32'h0000_0008, "R1", "split width bit readback");
        wr_reg(3'd0, 32'd1);
        count_de_to_eof(n);
        chk("R1", n, 2080, "de cycles for 1040-pixel lines");
        wr_reg(3'd0, 32'd0);
        wait_done();
        wr_reg(3'd4, 32'd3);

        // R2: tall frame, L = 1024 via aux bit 0.
        wr_reg(3'd1, 32'h0000_0000);
        wr_reg(3'd2, 32'h0000_0000);
        wr_reg(3'd3, 32'h0000_0001);
        rd_chk(3'd3, 32'h0000_0001, "R2", "height high bit readback");
        wr_reg(3'd0, 32'd1);
        count_de_to_eof(n);
        chk("R2", n, 16400, "de cycles for 1025 lines");
        wr_reg(3'd0, 32'd0);
        wait_done();
        chk("R4", fsync_o, 1'b0, "frame sync idle after stop");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule